// File: doc/BRIEF.md
# Complementary PWM Pair with Deadtime

This block drives one complementary pair of switch controls. A signed up-counter sweeps from a start value to a top value and reloads, so the period length is set by two numbers that may sit on either side of zero. Two edge compares set and clear one internal generator signal. Output B is active while the generator is high and output A is active while it is low. Each output has its own deadtime count that delays only its turn-on. Each output can also be inverted and disabled.

The start, top and both edge values are held in a shadow set. Writes to that set are invisible until software raises a load request, and the transfer then happens at the next period boundary. The deadtime counts take effect as soon as they are written. All pins are plain control and status pins. The block carries no data stream, so no valid/ready handshake exists and no back-pressure applies.

The block treats duty-cycle extremes as behaviour to be specified exactly. A fall compare equal to the top value leaves a one-clock low gap at every boundary. A fall compare one above the top value is never reached, which gives a gap-free 100% duty.

Top module: `cpwm_pair`

## Requirements
- R1: The counter resets to 0. While `run_i` is high it advances by one per clock. In the clock where it equals the active top value it asserts `period_start_o`, and on the next clock it loads the start value. The period is therefore top − start + 1 clocks.
- R2: The generator goes high one clock after the counter equals the rise value and low one clock after it equals the fall value. If both match at once, the fall match wins. With rise < fall inside the count range, the generator is high for fall − rise clocks per period.
- R3: A fall value equal to the top value with rise equal to start gives a generator low gap of exactly one clock per period. A fall value of top + 1 is never matched, so with rise equal to start output B stays active continuously and output A never becomes active.
- R4: Before deadtime and polarity are applied, B's active request equals the generator and A's equals its complement.
- R5: Each output's turn-on is delayed by its own deadtime count, and turn-off is not delayed. In steady state an output whose request is high for H clocks per period is active for max(0, H − deadtime) clocks per period.
- R6: With the one-clock gap of R3, output A is active for one clock per period when its deadtime is 0. It is never active when its deadtime is 1 or more.
- R7: Outputs A and B are never active in the same clock.
- R8: Inversion inputs `inv_a_i` and `inv_b_i` are applied after deadtime, so an inverted output is low exactly when it is active.
- R9: An output whose enable is low drives its inactive level, which equals its inversion input.
- R10: Configuration select codes are 0 = start, 1 = top, 2 = rise, 3 = fall, 4 = deadtime A and 5 = deadtime B. Codes 0 to 3 write only the shadow set. That set becomes active at the first period boundary after `ldok_set_i` is pulsed, and at that transfer `ldok_o` clears by itself. Codes 4 and 5 take effect immediately.
- R11: After reset, `ldok_o` is low and `cnt_o` is 0. With the enables low and the inversion inputs low, both PWM outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counter advance enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select (codes in R10) |
| cfg_wdata_i | input | 16 | Configuration write data, two's complement for the counter values |
| ldok_set_i | input | 1 | Requests transfer of the shadow set at the next boundary |
| out_en_a_i | input | 1 | Output A enable |
| out_en_b_i | input | 1 | Output B enable |
| inv_a_i | input | 1 | Output A inversion |
| inv_b_i | input | 1 | Output B inversion |
| pwm_a_o | output | 1 | Output A (complement side) |
| pwm_b_o | output | 1 | Output B (generator side) |
| cnt_o | output | 16 | Current signed counter value |
| period_start_o | output | 1 | High in the last clock of each period |
| ldok_o | output | 1 | Load request pending |

## Verification
The hardest case to reach is the interplay between a one-clock generator gap and a nonzero deadtime on the complementary side. That gap only appears when the fall compare lands exactly on the period boundary. The bench therefore uses a short period and sweeps every rise/fall pair inside the count range, plus the fall = top + 1 case. Each edge pair is combined with several deadtime pairs. For every combination the bench counts active clocks over two whole periods and compares them with the arithmetic prediction from R5, R6 and R3.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CNT_W = 16;
  localparam int SEL_W = 3;

  typedef logic signed [CNT_W-1:0] cnt_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_START  = 3'd0,
    SEL_TOP    = 3'd1,
    SEL_RISE   = 3'd2,
    SEL_FALL   = 3'd3,
    SEL_DEAD_A = 3'd4,
    SEL_DEAD_B = 3'd5
  } cfg_sel_e;

  typedef struct packed {
    cnt_t start;
    cnt_t top;
    cnt_t rise;
    cnt_t fall;
  } edge_set_t;
endpackage

// File: rtl/cpwm_shadow.sv
module cpwm_shadow
  import cpwm_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ldok_set_i,
  input  logic             reload_i,
  output edge_set_t        act_o,
  output cnt_t             next_start_o,
  output logic [DT_W-1:0]  dead_a_o,
  output logic [DT_W-1:0]  dead_b_o,
  output logic             ldok_o
);
  edge_set_t       shd_q, act_q;
  logic            ldok_q;
  logic [DT_W-1:0] dead_a_q, dead_b_q;
  logic            xfer;

  assign xfer = ldok_q && reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q    <= '0;
      act_q    <= '0;
      ldok_q   <= 1'b0;
      dead_a_q <= '0;
      dead_b_q <= '0;
    end else begin
      if (we_i) begin
        case (cfg_sel_e'(sel_i))
          SEL_START:  shd_q.start <= cnt_t'(wdata_i);
          SEL_TOP:    shd_q.top   <= cnt_t'(wdata_i);
          SEL_RISE:   shd_q.rise  <= cnt_t'(wdata_i);
          SEL_FALL:   shd_q.fall  <= cnt_t'(wdata_i);
          SEL_DEAD_A: dead_a_q    <= wdata_i[DT_W-1:0];
          SEL_DEAD_B: dead_b_q    <= wdata_i[DT_W-1:0];
          default: ;
        endcase
      end
      if (xfer) act_q <= shd_q;
      if (ldok_set_i)  ldok_q <= 1'b1;
      else if (xfer)   ldok_q <= 1'b0;
    end
  end

  assign act_o        = act_q;
  assign next_start_o = ldok_q ? shd_q.start : act_q.start;
  assign dead_a_o     = dead_a_q;
  assign dead_b_o     = dead_b_q;
  assign ldok_o       = ldok_q;

  AST_LDOK_AUTOCLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldok_q && reload_i && !ldok_set_i) |=> !ldok_q); // R10
  AST_ACTIVE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ldok_q && reload_i) |=> $stable(act_q)); // R10
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  cnt_t start_i,
  input  cnt_t top_i,
  output cnt_t cnt_o,
  output logic wrap_o
);
  cnt_t cnt_q;

  assign wrap_o = run_i && (cnt_q == top_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= start_i;
    else if (run_i)  cnt_q <= cnt_q + cnt_t'(1);
  end

  assign cnt_o = cnt_q;

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_o) |=> (cnt_q == $past(cnt_q) + cnt_t'(1))); // R1
  AST_WRAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == $past(start_i))); // R1
endmodule

// File: rtl/cpwm_edge_gen.sv
module cpwm_edge_gen
  import cpwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t cnt_i,
  input  cnt_t rise_i,
  input  cnt_t fall_i,
  output logic gen_o
);
  logic gen_q;
  logic hit_rise, hit_fall;

  assign hit_rise = (cnt_i == rise_i);
  assign hit_fall = (cnt_i == fall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gen_q <= 1'b0;
    else if (hit_fall) gen_q <= 1'b0;
    else if (hit_rise) gen_q <= 1'b1;
  end

  assign gen_o = gen_q;

  AST_FALL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == fall_i) |=> !gen_o); // R2
  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_i == rise_i) && (cnt_i != fall_i)) |=> gen_o); // R2
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            want_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            act_o
);
  logic            want_q;
  logic [DT_W-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      want_q <= 1'b0;
      wait_q <= '0;
    end else if (want_i != want_q) begin
      want_q <= want_i;
      wait_q <= want_i ? dt_i : '0;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign act_o = want_q && (wait_q == '0);

  AST_OFF_PROMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !want_i |=> !act_o); // R5
  AST_ON_DELAYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (want_i && !want_q && (dt_i != '0)) |=> !act_o); // R5
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
  import cpwm_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  input  logic             ldok_set_i,
  input  logic             out_en_a_i,
  input  logic             out_en_b_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             period_start_o,
  output logic             ldok_o
);
  localparam int NOUT = 2;

  edge_set_t       act;
  cnt_t            next_start, cnt;
  logic            wrap, gen;
  logic [DT_W-1:0] dead_a, dead_b;
  logic [DT_W-1:0] dt   [NOUT];
  logic [NOUT-1:0] want, on, en, inv, pin;

  cpwm_shadow #(.DT_W(DT_W)) shadow_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .ldok_set_i(ldok_set_i), .reload_i(wrap),
    .act_o(act), .next_start_o(next_start), .dead_a_o(dead_a),
    .dead_b_o(dead_b), .ldok_o(ldok_o)
  );

  cpwm_counter counter_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .start_i(next_start),
    .top_i(act.top), .cnt_o(cnt), .wrap_o(wrap)
  );

  cpwm_edge_gen edge_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .rise_i(act.rise),
    .fall_i(act.fall), .gen_o(gen)
  );

  // index 0 is output A (complement side), index 1 is output B
  assign want = {gen, ~gen};
  assign dt[0] = dead_a;
  assign dt[1] = dead_b;
  assign en   = {out_en_b_i, out_en_a_i};
  assign inv  = {inv_b_i, inv_a_i};

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    cpwm_deadtime #(.DT_W(DT_W)) dt_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .want_i(want[g]), .dt_i(dt[g]),
      .act_o(on[g])
    );
    assign pin[g] = en[g] ? (on[g] ^ inv[g]) : inv[g];
  end

  assign pwm_a_o        = pin[0];
  assign pwm_b_o        = pin[1];
  assign cnt_o          = cnt;
  assign period_start_o = wrap;

  AST_NEVER_BOTH_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(on[0] && on[1])); // R7
  AST_B_OFF_WITH_GEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen |=> !on[1]); // R4
endmodule

// File: tb/cpwm_pair_tb_top.sv
module cpwm_pair_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, we = 1'b0, ldok_set = 1'b0;
  logic [2:0] sel = '0;
  logic [15:0] wdata = '0;
  logic en_a = 1'b0, en_b = 1'b0, inv_a = 1'b0, inv_b = 1'b0;
  logic pwm_a, pwm_b, pstart, ldok;
  logic [15:0] cnt;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int ca, cb, cboth, cpulse;

  always #2 clk = ~clk; // 250 MHz

  cpwm_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_wdata_i(wdata), .ldok_set_i(ldok_set), .out_en_a_i(en_a),
    .out_en_b_i(en_b), .inv_a_i(inv_a), .inv_b_i(inv_b), .pwm_a_o(pwm_a),
    .pwm_b_o(pwm_b), .cnt_o(cnt), .period_start_o(pstart), .ldok_o(ldok)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input int s, input int d);
    @(negedge clk);
    we = 1'b1; sel = 3'(s); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic measure(input int n);
    ca = 0; cb = 0; cboth = 0; cpulse = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ca += int'(pwm_a); cb += int'(pwm_b);
      cboth += int'(pwm_a && pwm_b); cpulse += int'(pstart);
    end
  endtask

  task automatic load(input int st, input int tp, input int rs, input int fl,
                      input int da, input int db);
    int guard;
    wr(0, st); wr(1, tp); wr(2, rs); wr(3, fl); wr(4, da); wr(5, db);
    @(negedge clk); ldok_set = 1'b1;
    @(negedge clk); ldok_set = 1'b0;
    guard = 0;
    while (ldok && guard < 64) begin @(negedge clk); guard++; end
    check("R10 ldok autoclear", int'(ldok), 0);
    repeat (3 * (tp - st + 1) + 4) @(negedge clk);
  endtask

  function automatic int pos(input int v);
    return v > 0 ? v : 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int p, h, l, ea, eb;
    string ta, tb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 cnt", int'(cnt), 0);
    check("R11 ldok", int'(ldok), 0);
    check("R11 pwm_a", int'(pwm_a), 0);
    check("R11 pwm_b", int'(pwm_b), 0);
    run = 1'b1; en_a = 1'b1; en_b = 1'b1;

    // sweep: start, top, edges, deadtimes
    for (int si = 0; si < 2; si++) begin
      for (int ti = 0; ti < 2; ti++) begin
        int st, tp;
        st = (si == 0) ? -4 : -2;
        tp = (ti == 0) ? 3 : 5;
        for (int rs = st; rs <= tp; rs++) begin
          for (int fl = rs + 1; fl <= tp + 1; fl++) begin
            if (fl == tp + 1 && rs != st) continue;
            for (int dsel = 0; dsel < 3; dsel++) begin
              int da, db;
              da = (dsel == 1) ? 1 : (dsel == 2) ? 2 : 0;
              db = (dsel == 1) ? 2 : (dsel == 2) ? 1 : 0;
              load(st, tp, rs, fl, da, db);
              p = tp - st + 1;
              h = fl - rs;
              l = p - h;
              if (l == 0) begin ea = 0; eb = 2 * p; end
              else begin ea = 2 * pos(l - da); eb = 2 * pos(h - db); end
              ta = (l == 0) ? "R3 A" : (l == 1) ? "R6 A" : (da == 0) ? "R4 A" : "R5 A";
              tb = (l == 0) ? "R3 B" : (db == 0) ? "R2 B" : "R5 B";
              measure(2 * p);
              check(ta, ca, ea);
              check(tb, cb, eb);
              check("R7 overlap", cboth, 0);
              check("R1 period", cpulse, 2);
            end
          end
        end
      end
    end

    // R1 reload value after boundary
    load(-4, 3, -1, 2, 1, 1);
    while (!pstart) @(negedge clk);
    @(negedge clk);
    check("R1 reload start", int'($signed(cnt)), -4);

    // R8 inversion: L = 5, H = 3, dt 1
    inv_a = 1'b1;
    measure(16);
    check("R8 inverted A", ca, 16 - 2 * 4);
    inv_a = 1'b0;

    // R9 enable
    en_b = 1'b0; inv_b = 1'b0;
    measure(16);
    check("R9 disabled B low", cb, 0);
    inv_b = 1'b1;
    measure(16);
    check("R9 disabled B inverted level", cb, 16);
    en_b = 1'b1; inv_b = 1'b0;

    // R10 shadow without load request has no effect
    wr(1, 7); wr(3, 0);
    repeat (20) @(negedge clk);
    measure(16);
    check("R10 period unchanged", cpulse, 2);
    check("R10 B unchanged", cb, 2 * 2);
    // R10 deadtime writes act at once
    wr(5, 0);
    repeat (20) @(negedge clk);
    measure(16);
    check("R10 deadtime immediate", cb, 2 * 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule